// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a four-bank, single-data-rate synchronous DRAM from reset to the point where it accepts normal accesses. It owns the command pins (chip select, row strobe, column strobe, write enable), the bank and address buses, clock enable and the data mask. Every pin is a flop output loaded on the rising clock edge. A fixed order runs after reset. First a long settling wait made only of NOP cycles. Then one precharge of all banks, a train of auto-refresh commands, and one load of the mode register. After the last gap the block raises `init_done`, and the controller that follows may then start its own traffic.

The settling wait is `CLK_MHZ * SETTLE_US` cycles. The gaps after precharge (`TRP`), after each refresh (`TRFC`) and after the mode load (`TMRD`) are measured from command to command and are clamped to at least 2 cycles. The refresh count `NREF` is raised to 8 when it is set lower. The mode word `MODE_VAL` has a default of burst length 1, sequential order and CAS latency 3 (`13'h030`).

The state machine has eight states: SETTLE, PRECH, PRECH_GAP, REFRESH, REFRESH_GAP, LOADMODE, MODE_GAP and READY. Its transitions are:
- SETTLE→PRECH when the settle timer expires.
- PRECH→PRECH_GAP unconditionally.
- PRECH_GAP→REFRESH when the gap timer expires.
- REFRESH→REFRESH_GAP unconditionally.
- REFRESH_GAP→REFRESH when the gap expires and refreshes are still owed.
- REFRESH_GAP→LOADMODE when the gap expires and the count is complete.
- LOADMODE→MODE_GAP unconditionally.
- MODE_GAP→READY when the gap timer expires.
- READY→READY.

A synchronous reset moves any state back to SETTLE.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: Clock enable and every data-mask bit are high in every cycle, including the cycles spent in reset.
- R2: In the cycle after a reset edge, all four command pins are high (inhibit), `init_done` is 0 and `dbg_state` is 0. The address and bank buses are 0 in that cycle.
- R3: Let k count cycles after the last reset edge, so that k=0 is the inhibit cycle. With W = CLK_MHZ*SETTLE_US, cycles 1..W-1 carry NOP. NOP is cs,ras,cas,we = 0,1,1,1.
- R4: At k=W exactly one precharge is issued. Precharge is 0,0,1,0, with address bit 10 high, all other address bits 0 and bank 0.
- R5: Let P = W+TRP. NREF auto-refresh commands (0,0,0,1) appear at k = P + i*TRFC, for i = 0..NREF-1. Address and bank are 0 during each of them.
- R6: Let L = P+NREF*TRFC. The mode load (0,0,0,0) is issued at k=L, with MODE_VAL on the address bus and bank 0. It comes only after the last refresh.
- R7: `init_done` rises at k = L+TMRD and stays high with NOP on the pins until the next reset.
- R8: Every cycle between the commands above carries NOP. One run contains exactly one precharge, NREF refreshes and one mode load.
- R9: A reset asserted in any cycle wins over whatever the state machine would do at that edge. The next cycle shows inhibit with `init_done` low, and the whole sequence then repeats from R2.
- R10: `dbg_state` gives the current state: SETTLE=0, PRECH=1, PRECH_GAP=2, REFRESH=3, REFRESH_GAP=4, LOADMODE=5, MODE_GAP=6, READY=7.
- R11: A value of `NREF` below 8 is raised to 8, so eight refreshes are still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select, zero throughout |
| sd_addr | output | ADDR_W | Address bus: all-bank bit on precharge, mode word on mode load |
| sd_dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | High once the sequence is complete |
| dbg_state | output | 3 | Current state encoding (see R10) |

## Verification
Reset is synchronous, so it can land on the same edge at which the state machine would take a step of its own. The cases that matter are the edge that would leave the mode-load cycle and the edge that would raise `init_done`. The bench raises reset in the exact cycle that shows the mode load, and separately in the last cycle of the mode gap. It then requires that the following cycle shows inhibit, state 0 and `init_done` low rather than the step the state machine would have taken. After each of these collisions it follows the complete restarted sequence cycle by cycle, and it does the same after a reset dropped into the middle of the refresh train.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE      = 3'd0,
        ST_PRECH       = 3'd1,
        ST_PRECH_GAP   = 3'd2,
        ST_REFRESH     = 3'd3,
        ST_REFRESH_GAP = 3'd4,
        ST_LOADMODE    = 3'd5,
        ST_MODE_GAP    = 3'd6,
        ST_READY       = 3'd7
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_INHIBIT  = 4'b1111;
    localparam sd_cmd_t CMD_NOP      = 4'b0111;
    localparam sd_cmd_t CMD_PRECH    = 4'b0010;
    localparam sd_cmd_t CMD_REFRESH  = 4'b0001;
    localparam sd_cmd_t CMD_LOADMODE = 4'b0000;

    // Command presented on the pins while the machine sits in a state.
    function automatic sd_cmd_t cmd_of(init_state_e s);
        sd_cmd_t c;
        unique case (s)
            ST_PRECH:    c = CMD_PRECH;
            ST_REFRESH:  c = CMD_REFRESH;
            ST_LOADMODE: c = CMD_LOADMODE;
            default:     c = CMD_NOP;
        endcase
        return c;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3: an unloaded, non-zero count steps down by exactly one per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/init_refresh_tally.sv
module init_refresh_tally #(
    parameter int NREF = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    output logic full
);

    localparam int CW = $clog2(NREF + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump && count != CW'(NREF)) begin
            count <= count + 1'b1;
        end
    end

    assign full = (count == CW'(NREF));

    // R5: the tally never passes the programmed refresh total
    p_tally_bound_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(NREF));

    // R8: no refresh is requested once the total has been reached
    p_no_extra_refresh_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> !bump);

endmodule

// File: rtl/init_pin_reg.sv
module init_pin_reg
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W   = 13,
    parameter int                BA_W     = 2,
    parameter int                AP_BIT   = 10,
    parameter logic [ADDR_W-1:0] MODE_VAL = 'h030
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_e       st_nx,
    output sd_cmd_t           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);

    localparam logic [ADDR_W-1:0] ALLBANK_ADDR = ADDR_W'(1) << AP_BIT;

    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        unique case (st_nx)
            ST_PRECH:    addr_nx = ALLBANK_ADDR;
            ST_LOADMODE: addr_nx = MODE_VAL;
            default:     addr_nx = '0;
        endcase
    end

    // Pins load from the next state so they line up with the state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd   <= CMD_INHIBIT;
            addr  <= '0;
            ba    <= '0;
            ready <= 1'b0;
        end else begin
            cmd   <= cmd_of(st_nx);
            addr  <= addr_nx;
            ba    <= '0;
            ready <= (st_nx == ST_READY);
        end
    end

    // R7: once raised, ready persists and the pins idle on NOP
    p_ready_holds_r7: assert property (@(posedge clk) disable iff (rst)
        ready |=> (ready && cmd == CMD_NOP));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_MHZ   = 200,
    parameter int                SETTLE_US = 200,
    parameter int                TRP       = 3,
    parameter int                TRFC      = 9,
    parameter int                TMRD      = 2,
    parameter int                NREF      = 8,
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter int                DQM_W     = 2,
    parameter logic [ADDR_W-1:0] MODE_VAL  = 'h030
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done,
    output logic [2:0]        dbg_state
);

    localparam int WAIT_CYC = max_of(CLK_MHZ * SETTLE_US, 2);
    localparam int TRP_EFF  = max_of(TRP, 2);
    localparam int TRFC_EFF = max_of(TRFC, 2);
    localparam int TMRD_EFF = max_of(TMRD, 2);
    localparam int NREF_EFF = max_of(NREF, 8);
    localparam int SPAN     = max_of(WAIT_CYC, max_of(TRFC_EFF, max_of(TRP_EFF, TMRD_EFF)));
    localparam int TW       = $clog2(SPAN + 1);

    localparam logic [TW-1:0] LD_TRP  = TW'(TRP_EFF - 2);
    localparam logic [TW-1:0] LD_TRFC = TW'(TRFC_EFF - 2);
    localparam logic [TW-1:0] LD_TMRD = TW'(TMRD_EFF - 2);

    init_state_e   state, st_nx;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          ref_bump;
    logic          ref_full;
    sd_cmd_t       pin_cmd;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SETTLE;
        end else begin
            state <= st_nx;
        end
    end

    // Next state, timer loads and refresh bump
    always_comb begin
        st_nx    = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_bump = 1'b0;
        unique case (state)
            ST_SETTLE: begin
                if (tmr_done) st_nx = ST_PRECH;
            end
            ST_PRECH: begin
                st_nx    = ST_PRECH_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_TRP;
            end
            ST_PRECH_GAP: begin
                if (tmr_done) st_nx = ST_REFRESH;
            end
            ST_REFRESH: begin
                st_nx    = ST_REFRESH_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_TRFC;
                ref_bump = 1'b1;
            end
            ST_REFRESH_GAP: begin
                if (tmr_done) st_nx = ref_full ? ST_LOADMODE : ST_REFRESH;
            end
            ST_LOADMODE: begin
                st_nx    = ST_MODE_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_TMRD;
            end
            ST_MODE_GAP: begin
                if (tmr_done) st_nx = ST_READY;
            end
            ST_READY: begin
                st_nx = ST_READY;
            end
            default: begin
                st_nx = ST_SETTLE;
            end
        endcase
    end

    init_gap_timer #(
        .W       (TW),
        .RST_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    init_refresh_tally #(
        .NREF (NREF_EFF)
    ) u_tally (
        .clk  (clk),
        .rst  (rst),
        .bump (ref_bump),
        .full (ref_full)
    );

    init_pin_reg #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .AP_BIT   (10),
        .MODE_VAL (MODE_VAL)
    ) u_pins (
        .clk   (clk),
        .rst   (rst),
        .st_nx (st_nx),
        .cmd   (pin_cmd),
        .addr  (sd_addr),
        .ba    (sd_ba),
        .ready (init_done)
    );

    // Output process
    always_comb begin
        sd_cs_n   = pin_cmd.cs_n;
        sd_ras_n  = pin_cmd.ras_n;
        sd_cas_n  = pin_cmd.cas_n;
        sd_we_n   = pin_cmd.we_n;
        sd_cke    = 1'b1;
        sd_dqm    = '1;
        dbg_state = state;
    end

    // R4: precharge lasts one cycle and is followed by its gap
    p_prech_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRECH) |=> (state == ST_PRECH_GAP));

    // R3: precharge is entered only from the settle wait
    p_settle_first_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRECH) |-> ($past(state) == ST_SETTLE));

    // R5: every refresh command is a single cycle followed by its gap
    p_refresh_single_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REFRESH) |=> (state == ST_REFRESH_GAP));

    // R6: the mode load is reached only with the full refresh count done
    p_mode_after_refresh_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOADMODE) |-> ref_full);

    // R9: reset wins over any step of the machine
    p_reset_restart_r9: assert property (@(posedge clk)
        rst |=> (state == ST_SETTLE && !init_done && pin_cmd == CMD_INHIBIT));

endmodule

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;

    localparam int W0 = 200, TRP0 = 3, TRFC0 = 7, TMRD0 = 2, NR0 = 8;
    localparam logic [12:0] MODE0 = 13'h030;
    localparam int P0 = W0 + TRP0;
    localparam int L0 = P0 + NR0 * TRFC0;
    localparam int R0 = L0 + TMRD0;

    localparam int W1 = 20, TRP1 = 2, TRFC1 = 3, TMRD1 = 4, NR1_EXP = 8;
    localparam logic [12:0] MODE1 = 13'h022;
    localparam int R1_END = W1 + TRP1 + NR1_EXP * TRFC1 + TMRD1;

    localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010,
                           C_REF = 4'b0001, C_LMR = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic o0_cke, o0_cs, o0_ras, o0_cas, o0_we, o0_rdy;
    logic [1:0] o0_ba, o0_dqm;
    logic [12:0] o0_addr;
    logic [2:0] o0_dbg;
    logic o1_cke, o1_cs, o1_ras, o1_cas, o1_we, o1_rdy;
    logic [1:0] o1_ba, o1_dqm;
    logic [12:0] o1_addr;
    logic [2:0] o1_dbg;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_pre, n_ref, n_lmr;

    always #2.5 clk = ~clk;

    sdram_pwrup_seq #(.CLK_MHZ(200), .SETTLE_US(1), .TRP(TRP0), .TRFC(TRFC0),
        .TMRD(TMRD0), .NREF(NR0), .MODE_VAL(MODE0)) u0 (
        .clk(clk), .rst(rst), .sd_cke(o0_cke), .sd_cs_n(o0_cs), .sd_ras_n(o0_ras),
        .sd_cas_n(o0_cas), .sd_we_n(o0_we), .sd_ba(o0_ba), .sd_addr(o0_addr),
        .sd_dqm(o0_dqm), .init_done(o0_rdy), .dbg_state(o0_dbg));

    // NREF below the floor: eight refreshes are still expected (R11)
    sdram_pwrup_seq #(.CLK_MHZ(20), .SETTLE_US(1), .TRP(TRP1), .TRFC(TRFC1),
        .TMRD(TMRD1), .NREF(3), .MODE_VAL(MODE1)) u1 (
        .clk(clk), .rst(rst), .sd_cke(o1_cke), .sd_cs_n(o1_cs), .sd_ras_n(o1_ras),
        .sd_cas_n(o1_cas), .sd_we_n(o1_we), .sd_ba(o1_ba), .sd_addr(o1_addr),
        .sd_dqm(o1_dqm), .init_done(o1_rdy), .dbg_state(o1_dbg));

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                failures++;
                $display("FAIL R7 watchdog actual=still_running expected=finished");
                summary();
                $finish;
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic judge(string who, int k, int W, int TRP, int TRFC, int NR, int TMRD,
                         logic [12:0] mode, logic [3:0] cmd, logic [12:0] a, logic [1:0] ba,
                         logic cke, logic [1:0] dqm, logic rdy, logic [2:0] dbg);
        int P = W + TRP;
        int L = P + NR * TRFC;
        int R = L + TMRD;
        logic [3:0] ec;
        logic [12:0] ea = '0;
        logic erdy = 1'b0;
        int edbg;
        string tag;
        if (k == 0)      begin ec = C_INH; edbg = 0; tag = "R2"; end
        else if (k < W)  begin ec = C_NOP; edbg = 0; tag = "R3"; end
        else if (k == W) begin ec = C_PRE; edbg = 1; tag = "R4"; ea = 13'h400; end
        else if (k < P)  begin ec = C_NOP; edbg = 2; tag = "R8"; end
        else if (k < L) begin
            if ((k - P) % TRFC == 0) begin ec = C_REF; edbg = 3; tag = "R5"; end
            else                     begin ec = C_NOP; edbg = 4; tag = "R8"; end
        end
        else if (k == L) begin ec = C_LMR; edbg = 5; tag = "R6"; ea = mode; end
        else if (k < R)  begin ec = C_NOP; edbg = 6; tag = "R8"; end
        else             begin ec = C_NOP; edbg = 7; tag = "R7"; erdy = 1'b1; end
        if (who == "u1" && ec == C_REF) tag = "R11";
        chk(cmd == ec, tag, {who, " cmd"}, int'(cmd), int'(ec));
        chk(a == ea && ba == 2'b00, tag, {who, " addr/ba"}, int'({ba, a}), int'(ea));
        chk(rdy == erdy, "R7", {who, " init_done"}, int'(rdy), int'(erdy));
        chk(int'(dbg) == edbg, "R10", {who, " dbg_state"}, int'(dbg), edbg);
        chk(cke && dqm == 2'b11, "R1", {who, " cke/dqm"}, int'({cke, dqm}), 7);
        if (cmd == C_PRE) n_pre++;
        if (cmd == C_REF) n_ref++;
        if (cmd == C_LMR) n_lmr++;
    endtask

    // Called at the negedge of cycle k=0; judges cycles 0..upto.
    task automatic follow(int which, int upto);
        n_pre = 0; n_ref = 0; n_lmr = 0;
        for (int k = 0; k <= upto; k++) begin
            if (which == 0)
                judge("u0", k, W0, TRP0, TRFC0, NR0, TMRD0, MODE0,
                      {o0_cs, o0_ras, o0_cas, o0_we}, o0_addr, o0_ba, o0_cke, o0_dqm, o0_rdy, o0_dbg);
            else
                judge("u1", k, W1, TRP1, TRFC1, NR1_EXP, TMRD1, MODE1,
                      {o1_cs, o1_ras, o1_cas, o1_we}, o1_addr, o1_ba, o1_cke, o1_dqm, o1_rdy, o1_dbg);
            if (k < upto) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic check_reset_cycle(string tag);
        chk({o0_cs, o0_ras, o0_cas, o0_we} == C_INH, tag, "inhibit after reset",
            int'({o0_cs, o0_ras, o0_cas, o0_we}), int'(C_INH));
        chk(!o0_rdy, tag, "init_done after reset", int'(o0_rdy), 0);
        chk(o0_dbg == 3'd0, tag, "dbg_state after reset", int'(o0_dbg), 0);
        chk(o0_cke && o0_dqm == 2'b11, "R1", "cke/dqm in reset", int'({o0_cke, o0_dqm}), 7);
    endtask

    // Leaves the bench at the negedge of cycle k=0.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_cycle("R2");
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_full_sequence();
        do_reset();
        follow(0, R0 + 6);
        chk(n_pre == 1, "R8", "precharge count", n_pre, 1);
        chk(n_ref == NR0, "R8", "refresh count", n_ref, NR0);
        chk(n_lmr == 1, "R8", "mode load count", n_lmr, 1);
    endtask

    task automatic t_reset_mid_refresh();
        do_reset();
        follow(0, P0 + 2 * TRFC0 + 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_cycle("R9");
        rst = 1'b0;
        follow(0, R0 + 3);
        chk(n_ref == NR0, "R9", "refreshes after restart", n_ref, NR0);
    endtask

    // Reset collides with the edge that would leave the mode-load cycle.
    task automatic t_reset_at_mode_load();
        do_reset();
        follow(0, L0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_cycle("R9");
        rst = 1'b0;
        follow(0, R0 + 3);
    endtask

    // Reset collides with the edge that would raise init_done.
    task automatic t_reset_at_ready_rise();
        do_reset();
        follow(0, R0 - 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_cycle("R9");
        rst = 1'b0;
        follow(0, R0 + 3);
    endtask

    task automatic t_refresh_floor();
        do_reset();
        follow(1, R1_END + 4);
        chk(n_ref == NR1_EXP, "R11", "u1 refresh count", n_ref, NR1_EXP);
        chk(n_lmr == 1, "R11", "u1 mode load count", n_lmr, 1);
    endtask

    initial begin
        t_full_sequence();
        t_reset_mid_refresh();
        t_reset_at_mode_load();
        t_reset_at_ready_rise();
        t_refresh_floor();
        summary();
        $finish;
    end

endmodule